// File: doc/BRIEF.md
# Privileged System Instruction Checker

This block classifies the environment, privileged-return, wait, address-translation-flush and memory-ordering instructions of a 32-bit RISC-V hart with machine, supervisor and user modes. It takes one instruction word per cycle, together with the current privilege level and the trap-supervisor-return, trap-translation and I/O-to-memory fence-mapping status bits. One clock later it presents a single one-hot action, plus the side information that action needs: the environment-call cause code, the flush qualifiers, or the barrier sets.

A pipeline would place it next to the main decoder. The action vector steers trap entry, return handling, the wait controller, the translation cache and the memory-ordering unit. None of those is part of this block. The block only decides which one to engage and whether the instruction is legal in the present mode.

Top module: `sysck_top`

## Requirements
- R1: An all-zero SYSTEM word (0x00000073) yields action ECALL with cause 8 in user mode (priv 00), 9 in supervisor mode (01) and 11 in machine mode (11). Priv code 10 is treated as user mode everywhere.
- R2: The SYSTEM word with imm12 0x001 and rs1 and rd both zero yields action EBREAK in every mode.
- R3: The return-from-machine word (imm12 0x302, rs1 and rd zero) yields MRET only in machine mode. In any other mode it yields ILLEGAL.
- R4: The return-from-supervisor word (imm12 0x102, rs1 and rd zero) yields ILLEGAL in user mode. In supervisor mode it yields ILLEGAL when supervisor mode is not built or when tsr_i is 1. In machine mode it yields ILLEGAL when supervisor mode is not built. Otherwise it yields SRET.
- R5: The wait word (imm12 0x105, rs1 and rd zero) yields WFI in machine and supervisor mode and ILLEGAL in user mode.
- R6: The flush word (bits 31:25 = 0001001, rd zero) yields ILLEGAL in user mode, and in supervisor mode when tvm_i is 1. Otherwise it yields FLUSH.
- R7: On FLUSH, flush_addr_vld_o equals (rs1 != 0) and flush_asid_vld_o equals (rs2 != 0). Both flags are 0 for every other action.
- R8: For a FENCE (opcode 0001111, funct3 000), pred is bits 27:24 and succ is bits 23:20, each ordered I,O,R,W from MSB. When fiom_i is 1, I is ORed into R and O into W. The resulting R/W pairs appear on bar_pred_o/bar_succ_o (bit 1 = R, bit 0 = W) with action BARRIER.
- R9: A FENCE whose effective pred or succ R/W pair is 00 yields action NOP with zero barrier outputs. The fm field (bits 31:28), rs1 and rd do not change the result.
- R10: The exact word 0x8330000F yields BARRIER with bar_tso_o = 1 and both pairs 11, independent of fiom_i. Any other FENCE has bar_tso_o = 0.
- R11: Any other SYSTEM word with funct3 000 yields ILLEGAL.
- R12: act_o bits are ECALL 0, EBREAK 1, MRET 2, SRET 3, WFI 4, FLUSH 5, BARRIER 6, NOP 7, ILLEGAL 8. Outputs register the instruction applied with valid_i at the previous clock edge. At most one bit is set. All outputs are zero after reset, when valid_i was low, for other opcodes, and for SYSTEM or MISC-MEM words with funct3 not 000. The cause is zero for non-ECALL actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| tsr_i | input | 1 | Trap supervisor return status bit |
| tvm_i | input | 1 | Trap translation management status bit |
| fiom_i | input | 1 | Fence I/O maps onto memory ordering |
| act_o | output | 9 | One-hot action |
| ecall_cause_o | output | 4 | Environment-call exception cause |
| flush_addr_vld_o | output | 1 | Flush is limited to one address |
| flush_asid_vld_o | output | 1 | Flush is limited to one address space |
| bar_pred_o | output | 2 | Barrier predecessor set, R then W |
| bar_succ_o | output | 2 | Barrier successor set, R then W |
| bar_tso_o | output | 1 | Barrier is total-store-order |

## Verification
The only state is a single output register stage, so a wrong decode or a wrong legality choice shows on act_o on the cycle right after the word is applied. It cannot hide or appear later. A corrupted stage register would show either as two action bits at once or as a stale action after a cycle with valid_i low. Sweeping every privilege code and status-bit combination over every privileged word, plus every pred/succ pair under both fence mappings, exposes any term that reads the wrong mode, the wrong status bit or the wrong field.

// File: rtl/sysck_pkg.sv
package sysck_pkg;
   localparam int ILEN_C = 32;

   localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
   localparam logic [6:0] OPC_MEMORD = 7'b0001111;

   localparam int ACT_ECALL   = 0;
   localparam int ACT_EBREAK  = 1;
   localparam int ACT_MRET    = 2;
   localparam int ACT_SRET    = 3;
   localparam int ACT_WFI     = 4;
   localparam int ACT_FLUSH   = 5;
   localparam int ACT_BARRIER = 6;
   localparam int ACT_NOP     = 7;
   localparam int ACT_ILLEGAL = 8;
   localparam int ACT_N       = 9;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;

   localparam logic [11:0] IMM_EBREAK = 12'h001;
   localparam logic [11:0] IMM_SRET   = 12'h102;
   localparam logic [11:0] IMM_WFI    = 12'h105;
   localparam logic [11:0] IMM_MRET   = 12'h302;
   localparam logic [6:0]  F7_FLUSH   = 7'b0001001;

   localparam logic [31:0] WORD_TSO   = 32'h8330000F;
endpackage

// File: rtl/sysck_sys_decode.sv
module sysck_sys_decode
   import sysck_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1,
   parameter int ILEN      = 32,
   localparam int CAUSE_W  = 4
)(
   input  logic [ILEN-1:0]    instr_i,
   input  logic [1:0]         priv_i,
   input  logic               tsr_i,
   input  logic               tvm_i,
   output logic [ACT_N-1:0]   act_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic               addr_vld_o,
   output logic               asid_vld_o
);
   logic [11:0] imm12;
   logic [6:0]  f7;
   logic [4:0]  rs1, rs2, rd;
   logic        regs_zero;
   logic        in_m, in_s, in_u;

   assign imm12     = instr_i[31:20];
   assign f7        = instr_i[31:25];
   assign rs2       = instr_i[24:20];
   assign rs1       = instr_i[19:15];
   assign rd        = instr_i[11:7];
   assign regs_zero = (rs1 == 5'd0) && (rd == 5'd0);
   assign in_m      = (priv_i == PRIV_M);
   assign in_s      = (priv_i == PRIV_S);
   assign in_u      = !in_m && !in_s;

   always_comb begin
      act_o      = '0;
      cause_o    = '0;
      addr_vld_o = 1'b0;
      asid_vld_o = 1'b0;
      if (instr_i[31:7] == '0) begin
         act_o[ACT_ECALL] = 1'b1;
         cause_o          = {2'b10, in_u ? 2'b00 : priv_i};
      end else if (regs_zero && imm12 == IMM_EBREAK) begin
         act_o[ACT_EBREAK] = 1'b1;
      end else if (regs_zero && imm12 == IMM_MRET) begin
         if (in_m) act_o[ACT_MRET]    = 1'b1;
         else      act_o[ACT_ILLEGAL] = 1'b1;
      end else if (regs_zero && imm12 == IMM_SRET) begin
         if (HAS_SMODE && (in_m || (in_s && !tsr_i))) act_o[ACT_SRET]    = 1'b1;
         else                                          act_o[ACT_ILLEGAL] = 1'b1;
      end else if (regs_zero && imm12 == IMM_WFI) begin
         if (!in_u) act_o[ACT_WFI]     = 1'b1;
         else       act_o[ACT_ILLEGAL] = 1'b1;
      end else if (f7 == F7_FLUSH && rd == 5'd0) begin
         if (in_m || (in_s && !tvm_i)) begin
            act_o[ACT_FLUSH] = 1'b1;
            addr_vld_o       = (rs1 != 5'd0);
            asid_vld_o       = (rs2 != 5'd0);
         end else begin
            act_o[ACT_ILLEGAL] = 1'b1;
         end
      end else begin
         act_o[ACT_ILLEGAL] = 1'b1;
      end
   end
endmodule

// File: rtl/sysck_fence_decode.sv
module sysck_fence_decode
   import sysck_pkg::*;
#(
   parameter bit FIOM_EN = 1'b1,
   parameter int ILEN    = 32,
   localparam int SET_W  = 4,
   localparam int RW_W   = SET_W / 2
)(
   input  logic [ILEN-1:0]  instr_i,
   input  logic             fiom_i,
   output logic [ACT_N-1:0] act_o,
   output logic [RW_W-1:0]  pred_o,
   output logic [RW_W-1:0]  succ_o,
   output logic             tso_o
);
   logic [SET_W-1:0] pred_raw, succ_raw, pred_eff, succ_eff;
   logic             is_tso;

   assign pred_raw = instr_i[27:24];
   assign succ_raw = instr_i[23:20];
   assign is_tso   = (instr_i == WORD_TSO);

   generate
      if (FIOM_EN) begin : g_remap
         assign pred_eff = fiom_i ? {pred_raw[3:2], pred_raw[1:0] | pred_raw[3:2]} : pred_raw;
         assign succ_eff = fiom_i ? {succ_raw[3:2], succ_raw[1:0] | succ_raw[3:2]} : succ_raw;
      end else begin : g_plain
         assign pred_eff = pred_raw;
         assign succ_eff = succ_raw;
      end
   endgenerate

   always_comb begin
      act_o  = '0;
      pred_o = '0;
      succ_o = '0;
      tso_o  = 1'b0;
      if (is_tso) begin
         act_o[ACT_BARRIER] = 1'b1;
         pred_o             = 2'b11;
         succ_o             = 2'b11;
         tso_o              = 1'b1;
      end else if (pred_eff[1:0] != 2'b00 && succ_eff[1:0] != 2'b00) begin
         act_o[ACT_BARRIER] = 1'b1;
         pred_o             = pred_eff[1:0];
         succ_o             = succ_eff[1:0];
      end else begin
         act_o[ACT_NOP] = 1'b1;
      end
   end
endmodule

// File: rtl/sysck_top.sv
module sysck_top
   import sysck_pkg::*;
#(
   parameter int ILEN      = 32,
   parameter bit HAS_SMODE = 1'b1,
   parameter bit FIOM_EN   = 1'b1,
   localparam int CAUSE_W  = 4,
   localparam int RW_W     = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic [31:0]        instr_i,
   input  logic [1:0]         priv_i,
   input  logic               tsr_i,
   input  logic               tvm_i,
   input  logic               fiom_i,
   output logic [8:0]         act_o,
   output logic [3:0]         ecall_cause_o,
   output logic               flush_addr_vld_o,
   output logic               flush_asid_vld_o,
   output logic [1:0]         bar_pred_o,
   output logic [1:0]         bar_succ_o,
   output logic               bar_tso_o
);
   generate
      if (ILEN != ILEN_C) begin : g_bad_ilen
         $error("sysck_top: ILEN must be 32");
      end
   endgenerate

   logic [ACT_N-1:0]   sys_act, fen_act, act_d;
   logic [CAUSE_W-1:0] sys_cause;
   logic               sys_av, sys_sv;
   logic [RW_W-1:0]    fen_pred, fen_succ;
   logic               fen_tso;
   logic               is_sys, is_fen;

   assign is_sys = valid_i && instr_i[6:0] == OPC_SYSTEM && instr_i[14:12] == 3'b000;
   assign is_fen = valid_i && instr_i[6:0] == OPC_MEMORD && instr_i[14:12] == 3'b000;

   sysck_sys_decode #(.HAS_SMODE(HAS_SMODE), .ILEN(ILEN)) u_sys (
      .instr_i    (instr_i),
      .priv_i     (priv_i),
      .tsr_i      (tsr_i),
      .tvm_i      (tvm_i),
      .act_o      (sys_act),
      .cause_o    (sys_cause),
      .addr_vld_o (sys_av),
      .asid_vld_o (sys_sv)
   );

   sysck_fence_decode #(.FIOM_EN(FIOM_EN), .ILEN(ILEN)) u_fen (
      .instr_i (instr_i),
      .fiom_i  (fiom_i),
      .act_o   (fen_act),
      .pred_o  (fen_pred),
      .succ_o  (fen_succ),
      .tso_o   (fen_tso)
   );

   assign act_d = is_sys ? sys_act : (is_fen ? fen_act : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o            <= '0;
         ecall_cause_o    <= '0;
         flush_addr_vld_o <= 1'b0;
         flush_asid_vld_o <= 1'b0;
         bar_pred_o       <= '0;
         bar_succ_o       <= '0;
         bar_tso_o        <= 1'b0;
      end else begin
         act_o            <= act_d;
         ecall_cause_o    <= is_sys ? sys_cause : '0;
         flush_addr_vld_o <= is_sys && sys_av;
         flush_asid_vld_o <= is_sys && sys_sv;
         bar_pred_o       <= is_fen ? fen_pred : '0;
         bar_succ_o       <= is_fen ? fen_succ : '0;
         bar_tso_o        <= is_fen && fen_tso;
      end
   end
endmodule

// File: rtl/sysck_chk.sv
module sysck_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        valid_i,
   input logic [31:0] instr_i,
   input logic [1:0]  priv_i,
   input logic        tsr_i,
   input logic        tvm_i,
   input logic [8:0]  act_o,
   input logic [3:0]  ecall_cause_o,
   input logic        flush_addr_vld_o,
   input logic        flush_asid_vld_o,
   input logic        bar_tso_o
);
   logic user_sys;
   assign user_sys = valid_i && (priv_i == 2'b00 || priv_i == 2'b10) && instr_i[6:0] == 7'b1110011;

   assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act_o));

   assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> act_o == 9'd0);

   assert_user_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      user_sys |=> !act_o[2] && !act_o[3] && !act_o[4] && !act_o[5]);

   assert_tsr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && priv_i == 2'b01 && tsr_i) |=> !act_o[3]);

   assert_tvm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && priv_i == 2'b01 && tvm_i) |=> !act_o[5]);

   assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_addr_vld_o || flush_asid_vld_o) |-> act_o[5]);

   assert_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ecall_cause_o != 4'd0) |-> act_o[0]);

   assert_tso_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bar_tso_o |-> act_o[6]);
endmodule

bind sysck_top sysck_chk u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .valid_i          (valid_i),
   .instr_i          (instr_i),
   .priv_i           (priv_i),
   .tsr_i            (tsr_i),
   .tvm_i            (tvm_i),
   .act_o            (act_o),
   .ecall_cause_o    (ecall_cause_o),
   .flush_addr_vld_o (flush_addr_vld_o),
   .flush_asid_vld_o (flush_asid_vld_o),
   .bar_tso_o        (bar_tso_o)
);

// File: tb/sysck_top_tb.sv
module sysck_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [1:0]  priv_i = '0;
   logic        tsr_i = 1'b0, tvm_i = 1'b0, fiom_i = 1'b0;
   logic [8:0]  act_o;
   logic [3:0]  ecall_cause_o;
   logic        flush_addr_vld_o, flush_asid_vld_o;
   logic [1:0]  bar_pred_o, bar_succ_o;
   logic        bar_tso_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sysck_top u_dut (.*);

   typedef struct packed {
      logic [8:0] act;
      logic [3:0] cause;
      logic       av, sv;
      logic [1:0] pr, su;
      logic       tso;
   } res_t;

   function automatic res_t ref_model(input logic [31:0] w, input logic [1:0] pv,
                                      input logic tsr, input logic tvm, input logic fiom,
                                      input logic vld);
      res_t r = '0;
      logic [1:0] p = (pv == 2'b10) ? 2'b00 : pv;
      logic [3:0] pe, se;
      if (!vld || w[14:12] != 3'b000) return r;
      if (w[6:0] == 7'h73) begin
         if (w == 32'h00000073) begin r.act = 9'd1 << 0; r.cause = 4'd8 + {2'b00, p}; end
         else if (w == 32'h00100073) r.act = 9'd1 << 1;
         else if (w == 32'h30200073) r.act = (p == 2'b11) ? 9'd1 << 2 : 9'd1 << 8;
         else if (w == 32'h10200073) r.act = (p == 2'b11 || (p == 2'b01 && !tsr)) ? 9'd1 << 3 : 9'd1 << 8;
         else if (w == 32'h10500073) r.act = (p != 2'b00) ? 9'd1 << 4 : 9'd1 << 8;
         else if (w[31:25] == 7'b0001001 && w[11:7] == 5'd0) begin
            if (p == 2'b11 || (p == 2'b01 && !tvm)) begin
               r.act = 9'd1 << 5; r.av = (w[19:15] != 0); r.sv = (w[24:20] != 0);
            end else r.act = 9'd1 << 8;
         end else r.act = 9'd1 << 8;
      end else if (w[6:0] == 7'h0F) begin
         if (w == 32'h8330000F) begin r.act = 9'd1 << 6; r.pr = 2'b11; r.su = 2'b11; r.tso = 1'b1; end
         else begin
            pe = w[27:24]; se = w[23:20];
            if (fiom) begin pe[1] |= pe[3]; pe[0] |= pe[2]; se[1] |= se[3]; se[0] |= se[2]; end
            if (pe[1:0] != 0 && se[1:0] != 0) begin r.act = 9'd1 << 6; r.pr = pe[1:0]; r.su = se[1:0]; end
            else r.act = 9'd1 << 7;
         end
      end
      return r;
   endfunction

   task automatic check(input res_t exp, input string req);
      res_t got = {act_o, ecall_cause_o, flush_addr_vld_o, flush_asid_vld_o,
                   bar_pred_o, bar_succ_o, bar_tso_o};
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s instr=%h priv=%b act=%b/%b cause=%0d/%0d flg=%b%b/%b%b bar=%b%b%b/%b%b%b",
                  req, instr_i, priv_i, got.act, exp.act, got.cause, exp.cause,
                  got.av, got.sv, exp.av, exp.sv, got.pr, got.su, got.tso, exp.pr, exp.su, exp.tso);
      end
   endtask

   task automatic apply(input logic [31:0] w, input logic [1:0] pv, input logic tsr,
                        input logic tvm, input logic fiom, input logic vld, input string req);
      res_t e;
      @(negedge clk);
      instr_i = w; priv_i = pv; tsr_i = tsr; tvm_i = tvm; fiom_i = fiom; valid_i = vld;
      e = ref_model(w, pv, tsr, tvm, fiom, vld);
      @(posedge clk);
      #2;
      check(e, req);
   endtask

   localparam int NSYS = 17;
   logic [31:0] sys_words [NSYS] = '{
      32'h00000073, 32'h00100073, 32'h30200073, 32'h10200073, 32'h10500073,
      32'h12000073, 32'h12028073, 32'h12700073, 32'h12728073, 32'h120000F3,
      32'h30208073, 32'h00300073, 32'h000000F3, 32'h30001073, 32'h00000013,
      32'h0000100F, 32'h8330008F };
   string sys_tags [NSYS] = '{
      "R1", "R2", "R3", "R4", "R5", "R6", "R7", "R7", "R7", "R11",
      "R11", "R11", "R11", "R12", "R12", "R12", "R10" };

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check('0, "R12 reset");
      rst_n = 1'b1;
      for (int i = 0; i < NSYS; i++)
         for (int c = 0; c < 32; c++)
            apply(sys_words[i], c[1:0], c[2], c[3], c[4], 1'b1, sys_tags[i]);
      apply(32'h00000073, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R12 idle");
      apply(32'h8330000F, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R10 tso");
      apply(32'h8330000F, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R10 tso fiom");
      for (int ps = 0; ps < 256; ps++)
         for (int f = 0; f < 2; f++) begin
            logic [3:0] fm = ps[3:0] ^ ps[7:4];
            logic [4:0] r1 = 5'(ps * 3);
            logic [4:0] rd = 5'(ps + 7);
            logic [31:0] w = {fm, ps[7:0], r1, 3'b000, rd, 7'b0001111};
            apply(w, 2'(ps), 1'b0, 1'b0, f[0], 1'b1, "R8 R9 fence");
         end
      apply(32'h8330000F, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, "R10 before R12 idle");
      apply(32'h0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R12 idle after barrier");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule